// File: doc/BRIEF.md
# Exception entry state generator

This combinational block computes the machine state that a processor core loads when it enters a trap or a system call. It takes the current 64-bit machine state word, the address of the current instruction, a five-bit exception-type vector, a vector offset and the instruction word. From these it forms four results: the new state word, the return address to save, the status word to save and the address of the next fetch. Each result has its own write-valid flag for the register-update logic that follows.

A two-bit operation select tells the block which entry is in progress. Deciding whether a trap condition holds is not done here, and neither is writing the register file. The caller asserts the trap operation only when a trap is to be taken.

Bits are named most-significant-first: bit 0 is the MSB of a 64-bit word, and bit n sits at vector index 63-n. For the 32-bit instruction word, instruction bit n sits at vector index 31-n.

Top module: `exc_entry_gen`

## Requirements
- R1: When the operation is trap (op_sel_i=1) or system call (op_sel_i=2), the new state has these bits cleared: 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61 and 62.
- R2: When the operation is trap or system call, new-state bits 0 (64-bit mode) and 63 (little-endian) are 1.
- R3: The two-bit transaction-state field at bits 29:30 becomes 01 when it was 10. Any other value passes through unchanged.
- R4: For a trap, the saved address equals the current instruction address.
- R5: For a trap or a system call, the next address is the vector offset, zero-extended and shifted left by 4.
- R6: For a trap, the saved status is the old state with these changes. Bits 33 to 36 are cleared. Bit 42 is cleared. Bit 46 is set exactly when the exception type is zero. Bit 45 takes type bit 1, bit 43 takes type bit 0, bit 47 takes type bit 3 and bit 44 takes type bit 4, where type bit k is exc_type_i[k].
- R7: For a system call, the saved address is the current instruction address plus 4, modulo 2^64.
- R8: For a system call, the saved status keeps old bits 0 to 32, 37 to 41 and 48 to 63, and clears bits 33 to 36 and 42 to 47.
- R9: For a system call, new-state bit 3 (hypervisor) is 1 exactly when the level field (instruction bits 20 to 26, insn_i[11:5]) equals 1.
- R10: For a trap, new-state bit 3 and every bit not named in R1 to R3 equal the old state. For a system call, every bit not named in R1 to R3 or R9 equals the old state.
- R11: All four valid flags are 1 for trap and system call. For op_sel_i equal to 0 or 3, all flags are 0 and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| state_i | input | 64 | Current machine state word |
| cia_i | input | 64 | Current instruction address |
| exc_type_i | input | 5 | Exception-type vector |
| vec_off_i | input | VEC_W | Vector offset, in 16-byte units |
| insn_i | input | 32 | Instruction word |
| op_sel_i | input | 2 | 0 idle, 1 trap, 2 system call, 3 idle |
| new_state_o | output | 64 | New machine state word |
| new_state_vld_o | output | 1 | Write-valid for new state |
| save_addr_o | output | 64 | Return address to save |
| save_addr_vld_o | output | 1 | Write-valid for saved address |
| save_stat_o | output | 64 | Status word to save |
| save_stat_vld_o | output | 1 | Write-valid for saved status |
| next_addr_o | output | 64 | Next fetch address |
| next_addr_vld_o | output | 1 | Write-valid for next address |

## Verification
The block has no internal state, so a wrong mask or a wrong index shows at the outputs as soon as the inputs settle. No clock edge is involved. A bit-numbering slip, such as the MSB-first index mirrored, moves a cleared or set bit to its mirror position. Random state words expose this almost at once. The transaction-state demotion, the zero-type trap cause and the level-equals-1 hypervisor rule are rare under random inputs, so each is driven directly, as is an instruction address near the top of the range for the wrapping add.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 64;

  // MSB-first positions
  localparam int B_SF = 0,  B_HV = 3,  B_TS_A = 29, B_TS_B = 30, B_TME = 31;
  localparam int B_VEC = 38, B_VSX = 40, B_EE = 48, B_PR = 49, B_FPA = 50;
  localparam int B_FE0 = 52, B_TE_A = 53, B_TE_B = 54, B_FE1 = 55;
  localparam int B_IR = 58, B_DR = 59, B_PMM = 61, B_RI = 62, B_LE = 63;
  localparam int C_TMBAD = 42, C_FP = 43, C_ILL = 44, C_PRIV = 45, C_TRAP = 46, C_ADR = 47;

  // vector indices
  localparam int I_SF = XLEN-1-B_SF;
  localparam int I_HV = XLEN-1-B_HV;
  localparam int I_TS_A = XLEN-1-B_TS_A;
  localparam int I_TS_B = XLEN-1-B_TS_B;
  localparam int I_LE = XLEN-1-B_LE;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0, OP_TRAP = 2'd1, OP_SYSCALL = 2'd2, OP_RSVD = 2'd3
  } op_e;

  function automatic logic [XLEN-1:0] ibm_bit(int b);
    return {{(XLEN-1){1'b0}}, 1'b1} << (XLEN-1-b);
  endfunction

  function automatic logic [XLEN-1:0] ibm_span(int first, int last);
    logic [XLEN-1:0] m;
    m = '0;
    for (int b = first; b <= last; b++) m |= ibm_bit(b);
    return m;
  endfunction

  localparam logic [XLEN-1:0] CLR_MASK =
      ibm_bit(B_TME) | ibm_bit(B_VEC) | ibm_bit(B_VSX) | ibm_bit(B_EE) |
      ibm_bit(B_PR) | ibm_bit(B_FPA) | ibm_bit(B_FE0) | ibm_bit(B_TE_A) |
      ibm_bit(B_TE_B) | ibm_bit(B_FE1) | ibm_bit(B_IR) | ibm_bit(B_DR) |
      ibm_bit(B_PMM) | ibm_bit(B_RI);
  localparam logic [XLEN-1:0] GAP_MASK   = ibm_span(33, 36);
  localparam logic [XLEN-1:0] CAUSE_MASK = ibm_span(42, 47);
endpackage

// File: rtl/exc_state_mask.sv
module exc_state_mask
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0] state_i,
  input  logic            active_i,
  input  logic            is_sc_i,
  input  logic [6:0]      lev_i,
  output logic [XLEN-1:0] new_state_o
);
  logic ts_active;
  assign ts_active = state_i[I_TS_A] & ~state_i[I_TS_B];

  always_comb begin
    new_state_o = (state_i & ~CLR_MASK) | ibm_bit(B_SF) | ibm_bit(B_LE);
    if (ts_active) begin
      new_state_o[I_TS_A] = 1'b0;
      new_state_o[I_TS_B] = 1'b1;
    end
    if (is_sc_i) new_state_o[I_HV] = (lev_i == 7'd1);
    if (!active_i) new_state_o = '0;
  end

  always_comb begin
    if (active_i) begin
      assert_clear_bits_R1: assert ((new_state_o & CLR_MASK) == '0)
        else $error("clear mask violated");
      assert_mode_set_R2: assert (new_state_o[I_SF] && new_state_o[I_LE])
        else $error("mode bits not set");
      assert_ts_demote_R3: assert (!(new_state_o[I_TS_A] && !new_state_o[I_TS_B]))
        else $error("transaction state left active");
      if (!is_sc_i) begin
        assert_hv_keep_R10: assert (new_state_o[I_HV] == state_i[I_HV])
          else $error("hv changed on trap");
      end
    end
  end
endmodule

// File: rtl/exc_status_save.sv
module exc_status_save
  import exc_entry_pkg::*;
(
  input  logic [XLEN-1:0] state_i,
  input  logic            active_i,
  input  logic            is_sc_i,
  input  logic [4:0]      exc_type_i,
  output logic [XLEN-1:0] save_stat_o
);
  logic [XLEN-1:0] cause;

  always_comb begin
    cause = '0;
    if (exc_type_i == 5'd0) cause |= ibm_bit(C_TRAP);
    if (exc_type_i[1])      cause |= ibm_bit(C_PRIV);
    if (exc_type_i[0])      cause |= ibm_bit(C_FP);
    if (exc_type_i[3])      cause |= ibm_bit(C_ADR);
    if (exc_type_i[4])      cause |= ibm_bit(C_ILL);
    if (is_sc_i)            cause = '0;
  end

  always_comb begin
    save_stat_o = (state_i & ~GAP_MASK & ~CAUSE_MASK) | cause;
    if (!active_i) save_stat_o = '0;
  end

  always_comb begin
    if (active_i) begin
      assert_gap_clear_R6: assert ((save_stat_o & GAP_MASK) == '0)
        else $error("gap bits set");
      assert_tmbad_clear_R6: assert ((save_stat_o & ibm_bit(C_TMBAD)) == '0)
        else $error("tm failure bit set");
      if (is_sc_i) begin
        assert_sc_cause_R8: assert ((save_stat_o & CAUSE_MASK) == '0)
          else $error("cause bits set on system call");
      end
    end
  end
endmodule

// File: rtl/exc_entry_gen.sv
module exc_entry_gen
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 60
) (
  input  logic [XLEN-1:0]  state_i,
  input  logic [XLEN-1:0]  cia_i,
  input  logic [4:0]       exc_type_i,
  input  logic [VEC_W-1:0] vec_off_i,
  input  logic [31:0]      insn_i,
  input  logic [1:0]       op_sel_i,
  output logic [XLEN-1:0]  new_state_o,
  output logic             new_state_vld_o,
  output logic [XLEN-1:0]  save_addr_o,
  output logic             save_addr_vld_o,
  output logic [XLEN-1:0]  save_stat_o,
  output logic             save_stat_vld_o,
  output logic [XLEN-1:0]  next_addr_o,
  output logic             next_addr_vld_o
);
  localparam int VEC_SHIFT = 4;
  localparam int LEV_LSB = 5;
  localparam int LEV_W = 7;

  op_e             op;
  logic            is_trap, is_sc, active;
  logic [LEV_W-1:0] lev;
  logic [19:0]     insn_unused;

  assign op      = op_e'(op_sel_i);
  assign is_trap = (op == OP_TRAP);
  assign is_sc   = (op == OP_SYSCALL);
  assign active  = is_trap | is_sc;
  // level field: instruction bits 20..26 (MSB-first)
  assign lev         = insn_i[LEV_LSB +: LEV_W];
  assign insn_unused = {insn_i[31:LEV_LSB+LEV_W], insn_i[LEV_LSB-1:0]};

  exc_state_mask u_mask (
    .state_i     (state_i),
    .active_i    (active),
    .is_sc_i     (is_sc),
    .lev_i       (lev),
    .new_state_o (new_state_o)
  );

  exc_status_save u_save (
    .state_i     (state_i),
    .active_i    (active),
    .is_sc_i     (is_sc),
    .exc_type_i  (exc_type_i),
    .save_stat_o (save_stat_o)
  );

  always_comb begin
    save_addr_o = '0;
    next_addr_o = '0;
    if (active) next_addr_o = XLEN'(vec_off_i) << VEC_SHIFT;
    if (is_trap) save_addr_o = cia_i;
    if (is_sc)   save_addr_o = cia_i + XLEN'(4);
  end

  assign new_state_vld_o = active;
  assign save_addr_vld_o = active;
  assign save_stat_vld_o = active;
  assign next_addr_vld_o = active;

  always_comb begin
    if (is_sc) begin
      assert_sc_addr_R7: assert (save_addr_o - cia_i == XLEN'(4))
        else $error("system call return address");
    end
    if (!new_state_vld_o) begin
      assert_idle_R11: assert (new_state_o == '0 && save_stat_o == '0)
        else $error("idle outputs not zero");
    end
  end
endmodule

// File: tb/tb_exc_entry_gen.sv
module tb_exc_entry_gen;
  localparam int VEC_W = 60;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [63:0] state_i, cia_i;
  logic [4:0]  exc_type_i;
  logic [VEC_W-1:0] vec_off_i;
  logic [31:0] insn_i;
  logic [1:0]  op_sel_i;
  logic [63:0] new_state_o, save_addr_o, save_stat_o, next_addr_o;
  logic new_state_vld_o, save_addr_vld_o, save_stat_vld_o, next_addr_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  exc_entry_gen #(.VEC_W(VEC_W)) dut (.*);

  function automatic logic [63:0] bm(int b);
    return 64'd1 << (63 - b);
  endfunction

  function automatic logic [63:0] clr_bits();
    logic [63:0] m = '0;
    int list [14] = '{31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62};
    foreach (list[k]) m |= bm(list[k]);
    return m;
  endfunction

  function automatic logic [63:0] exp_state(logic [63:0] s, bit sc, logic [31:0] ins);
    logic [63:0] n;
    n = (s & ~clr_bits()) | bm(0) | bm(63);
    if ((s & bm(29)) != 0 && (s & bm(30)) == 0) n = (n & ~bm(29)) | bm(30);
    if (sc) n = (ins[11:5] == 7'd1) ? (n | bm(3)) : (n & ~bm(3));
    return n;
  endfunction

  function automatic logic [63:0] exp_stat(logic [63:0] s, bit sc, logic [4:0] t);
    logic [63:0] r = s;
    for (int b = 33; b <= 36; b++) r &= ~bm(b);
    for (int b = 42; b <= 47; b++) r &= ~bm(b);
    if (!sc) begin
      if (t == 0) r |= bm(46);
      if (t[1])   r |= bm(45);
      if (t[0])   r |= bm(43);
      if (t[3])   r |= bm(47);
      if (t[4])   r |= bm(44);
    end
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [63:0] s, logic [63:0] c,
                       logic [4:0] t, logic [VEC_W-1:0] v, logic [31:0] ins);
    logic [63:0] es, nm;
    bit sc, act;
    @(negedge clk);
    op_sel_i = op; state_i = s; cia_i = c; exc_type_i = t; vec_off_i = v; insn_i = ins;
    #5;
    sc  = (op == 2'd2);
    act = (op == 2'd1) || sc;
    check("R11 valid flags",
          {60'd0, new_state_vld_o, save_addr_vld_o, save_stat_vld_o, next_addr_vld_o},
          act ? 64'hF : 64'h0);
    if (!act) begin
      check("R11 idle data",
            new_state_o | save_addr_o | save_stat_o | next_addr_o, 64'd0);
      return;
    end
    es = exp_state(s, sc, ins);
    check("R1 cleared bits", new_state_o & clr_bits(), 64'd0);
    check("R2 mode bits", new_state_o & (bm(0) | bm(63)), bm(0) | bm(63));
    check("R3 ts field", new_state_o & (bm(29) | bm(30)), es & (bm(29) | bm(30)));
    if (sc) check("R9 hv bit", new_state_o & bm(3), es & bm(3));
    nm = clr_bits() | bm(0) | bm(63) | bm(29) | bm(30) | (sc ? bm(3) : 64'd0);
    check("R10 kept bits", new_state_o & ~nm, s & ~nm);
    check("R5 next addr", next_addr_o, {v, 4'b0000});
    if (sc) begin
      check("R7 sc save addr", save_addr_o, c + 64'd4);
      check("R8 sc status", save_stat_o, exp_stat(s, 1'b1, t));
    end else begin
      check("R4 trap save addr", save_addr_o, c);
      check("R6 trap status", save_stat_o, exp_stat(s, 1'b0, t));
    end
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    op_sel_i = '0; state_i = '0; cia_i = '0; exc_type_i = '0; vec_off_i = '0; insn_i = '0;
    void'($urandom(32'd1234));
    // reset-like idle state
    apply(2'd0, 64'd0, 64'd0, 5'd0, '0, 32'd0);
    // R3 demotion corner cases
    apply(2'd1, bm(29), 64'h1000, 5'd0, 60'h70, 32'd0);
    apply(2'd1, bm(30), 64'h1000, 5'd2, 60'h70, 32'd0);
    apply(2'd2, bm(29) | bm(30), 64'h1000, 5'd0, 60'hC0, 32'd0);
    apply(2'd2, ~64'd0, 64'h2000, 5'd0, 60'hC0, 32'd1 << 5);
    // R9 level values
    apply(2'd2, 64'd0, 64'h4, 5'd0, 60'hC0, 32'd1 << 5);
    apply(2'd2, bm(3), 64'h4, 5'd0, 60'hC0, 32'd2 << 5);
    apply(2'd2, bm(3), 64'h4, 5'd0, 60'hC0, 32'd0);
    // R7 wrap
    apply(2'd2, r64(), 64'hFFFF_FFFF_FFFF_FFFE, 5'd0, '1, 32'hFFFF_FFFF);
    // R6 cause bits, one type bit at a time
    for (int k = 0; k < 5; k++) apply(2'd1, ~64'd0, 64'h3000, 5'd1 << k, 60'h7, 32'd0);
    apply(2'd1, ~64'd0, 64'h3000, 5'd0, 60'h7, 32'd0);
    apply(2'd1, bm(3), 64'h3000, 5'd31, 60'h7, 32'd1 << 5);
    apply(2'd3, ~64'd0, ~64'd0, 5'd31, '1, 32'hFFFF_FFFF);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ins;
      ins = $urandom;
      if ($urandom_range(3) == 0) ins[11:5] = 7'd1;
      apply(2'($urandom_range(3)), r64(), r64(), 5'($urandom_range(31)),
            VEC_W'(r64()), ins);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule